// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog counter clocked by a slow dedicated clock and reached through a small register bus. The bus has a two-bit address, sixteen-bit write data, a write enable and combinational read data. Software starts the counter, then clears it at regular intervals. If the count reaches a programmed ten-bit limit before a clear arrives, the block raises a non-maskable interrupt or a reset request, as the mode field selects. After that match the counter goes back to zero by itself and keeps counting.

A sixteen-bit key register guards every change to the control and limit registers. While it holds 0x0096 those writes take effect. Any other value locks them again, and locked writes are dropped without a trace. Reads are never gated.

Run control is a two-state machine, `ST_STOPPED` and `ST_COUNTING`. An accepted control write whose run code is anything other than 0xA takes the `GO` transition from `ST_STOPPED` to `ST_COUNTING`. An accepted control write with run code 0xA takes the `HALT` transition back to `ST_STOPPED`. Every other cycle keeps the current state (`STAY`).

Top module: `kwdt_top`

## Requirements
- R1: After reset the key register reads 0x0000 (locked), control reads 0x000A (stopped, mode 00, status 0), the limit reads 0x03FF, the count reads 0, and both `nmi_o` and `rst_req_o` are low.
- R2: Register addresses are 0 = key, 1 = control, 2 = limit, 3 = count (read-only). Writes to control and limit take effect only while the key register holds 0x0096. Writing any other value to the key register locks them again. Locked writes change nothing, and reads work whether the registers are locked or not.
- R3: The limit lives in bits [9:0] of address 2. The other read bits are 0.
- R4: The control run code sits in bits [3:0]. Writing 0xA stops the counter, which then holds its value. Any other code starts counting from the held value on the next edge.
- R5: Writing 1 to control bit 15 (the clear bit) sets the count to 0 at that write's edge, so a full new period begins. Bit 15 always reads 0.
- R6: When the running count equals the limit, the next edge puts the count back to 0 and counting goes on. Compare matches are therefore LIMIT+1 edges apart.
- R7: Mode field control[9:8] = 2'b01 selects the interrupt. On a match, status bit control[14] becomes 1 at the next edge and stays set, and `nmi_o` follows it. Only an accepted write with the clear bit set returns it to 0.
- R8: Mode 2'b00, and also 2'b10 and 2'b11, select reset. `rst_req_o` is high for exactly the one cycle after the edge that ends a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dedicated watchdog clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | Write enable, one write per cycle |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| nmi_o | output | 1 | Interrupt request level (follows status bit) |
| rst_req_o | output | 1 | One-cycle reset request pulse |

## Verification
The hardest state to reach from the ports is a locked block that has a pending interrupt while it is running. In that state a clear write must fail to drop the status, and nothing else can drop it either. The stimulus unlocks the block, arms interrupt mode with a short limit, and waits for the status bit. It then relocks, sends a clear that must be ignored, and only after that unlocks again and clears the status properly. A long limit of 639 is also timed edge by edge to confirm the LIMIT+1 period.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 2;
    localparam int LIM_W  = 10;
    localparam int RUN_W  = 4;
    localparam int MODE_W = 2;

    localparam logic [DATA_W-1:0] UNLOCK_KEY = 16'h0096;
    localparam logic [RUN_W-1:0]  RUN_HALT   = 4'hA;
    localparam logic [MODE_W-1:0] MODE_IRQ   = 2'b01;
    localparam logic [LIM_W-1:0]  LIM_RESET  = '1;

    localparam int BIT_CLR  = 15;
    localparam int BIT_STAT = 14;
    localparam int MODE_LO  = 8;

    typedef enum logic [ADDR_W-1:0] {
        A_KEY   = 2'd0,
        A_CTRL  = 2'd1,
        A_LIMIT = 2'd2,
        A_COUNT = 2'd3
    } reg_addr_t;

    typedef enum logic {
        ST_STOPPED  = 1'b0,
        ST_COUNTING = 1'b1
    } run_state_t;
endpackage

// File: rtl/kwdt_regfile.sv
module kwdt_regfile
    import kwdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic [LIM_W-1:0]  count,
    input  logic              irq_stat,
    output logic              unlocked,
    output logic [LIM_W-1:0]  limit,
    output logic [MODE_W-1:0] mode,
    output logic              clr_strobe,
    output logic              go_req,
    output logic              halt_req,
    output logic [DATA_W-1:0] bus_rdata
);
    logic [DATA_W-1:0] key_q;
    logic [RUN_W-1:0]  run_q;
    logic [MODE_W-1:0] mode_q;
    logic [LIM_W-1:0]  lim_q;
    logic              wr_key, wr_ctrl, wr_lim;

    assign unlocked = (key_q == UNLOCK_KEY);
    assign wr_key   = bus_we && (bus_addr == A_KEY);
    assign wr_ctrl  = bus_we && (bus_addr == A_CTRL)  && unlocked;
    assign wr_lim   = bus_we && (bus_addr == A_LIMIT) && unlocked;

    assign clr_strobe = wr_ctrl && bus_wdata[BIT_CLR];
    assign go_req     = wr_ctrl && (bus_wdata[RUN_W-1:0] != RUN_HALT);
    assign halt_req   = wr_ctrl && (bus_wdata[RUN_W-1:0] == RUN_HALT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_q <= '0;
        end else if (wr_key) begin
            key_q <= bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= RUN_HALT;
            mode_q <= '0;
        end else if (wr_ctrl) begin
            run_q  <= bus_wdata[RUN_W-1:0];
            mode_q <= bus_wdata[MODE_LO +: MODE_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lim_q <= LIM_RESET;
        end else if (wr_lim) begin
            lim_q <= bus_wdata[LIM_W-1:0];
        end
    end

    assign limit = lim_q;
    assign mode  = mode_q;

    always_comb begin
        bus_rdata = '0;
        unique case (reg_addr_t'(bus_addr))
            A_KEY:   bus_rdata = key_q;
            A_CTRL: begin
                bus_rdata[RUN_W-1:0]          = run_q;
                bus_rdata[MODE_LO +: MODE_W]  = mode_q;
                bus_rdata[BIT_STAT]           = irq_stat;
            end
            A_LIMIT: bus_rdata[LIM_W-1:0] = lim_q;
            A_COUNT: bus_rdata[LIM_W-1:0] = count;
        endcase
    end
endmodule

// File: rtl/kwdt_runfsm.sv
module kwdt_runfsm
    import kwdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go_req,
    input  logic halt_req,
    output logic counting
);
    run_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STOPPED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        counting = 1'b0;
        unique case (state_q)
            ST_STOPPED: begin
                if (go_req) state_d = ST_COUNTING;
            end
            ST_COUNTING: begin
                counting = 1'b1;
                if (halt_req) state_d = ST_STOPPED;
            end
        endcase
    end
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter
    import kwdt_pkg::*;
#(
    parameter int CW = LIM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              counting,
    input  logic              clr,
    input  logic [CW-1:0]     limit,
    input  logic [MODE_W-1:0] mode,
    output logic [CW-1:0]     count,
    output logic              irq_stat,
    output logic              rst_pulse
);
    logic [CW-1:0] cnt_q;
    logic          stat_q, pulse_q, hit;

    assign hit = counting && !clr && (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt_q <= '0;
        else if (clr)      cnt_q <= '0;
        else if (hit)      cnt_q <= '0;
        else if (counting) cnt_q <= cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q  <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= hit && (mode != MODE_IRQ);
            if (clr)                            stat_q <= 1'b0;
            else if (hit && (mode == MODE_IRQ)) stat_q <= 1'b1;
        end
    end

    assign count     = cnt_q;
    assign irq_stat  = stat_q;
    assign rst_pulse = pulse_q;
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
    import kwdt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    input  logic        bus_we,
    output logic [15:0] bus_rdata,
    output logic        nmi_o,
    output logic        rst_req_o
);
    logic              unlocked, clr_strobe, go_req, halt_req, counting, irq_stat;
    logic [LIM_W-1:0]  limit, count;
    logic [MODE_W-1:0] mode;

    kwdt_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .count(count), .irq_stat(irq_stat), .unlocked(unlocked),
        .limit(limit), .mode(mode), .clr_strobe(clr_strobe), .go_req(go_req),
        .halt_req(halt_req), .bus_rdata(bus_rdata)
    );

    kwdt_runfsm u_fsm (
        .clk(clk), .rst_n(rst_n), .go_req(go_req), .halt_req(halt_req),
        .counting(counting)
    );

    kwdt_counter #(.CW(LIM_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .counting(counting), .clr(clr_strobe),
        .limit(limit), .mode(mode), .count(count), .irq_stat(irq_stat),
        .rst_pulse(rst_req_o)
    );

    assign nmi_o = irq_stat;
endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk
    import kwdt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              unlocked,
    input logic              counting,
    input logic              clr,
    input logic [LIM_W-1:0]  limit,
    input logic [LIM_W-1:0]  count,
    input logic [MODE_W-1:0] mode,
    input logic              nmi_o,
    input logic              rst_req_o
);
    AST_LOCKED_LIMIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (bus_we && bus_addr == A_LIMIT && !unlocked) |=> $stable(limit)); // R2
    AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!counting && !clr) |=> $stable(count)); // R4
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n) clr |=> (count == '0)); // R5
    AST_MATCH_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (counting && !clr && count == limit) |=> (count == '0)); // R6
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (nmi_o && !clr) |=> nmi_o); // R7
    AST_RST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) rst_req_o |-> $past(counting && !clr && count == limit && mode != MODE_IRQ)); // R8
endmodule

bind kwdt_top kwdt_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .unlocked(unlocked), .counting(counting), .clr(clr_strobe), .limit(limit),
    .count(count), .mode(mode), .nmi_o(nmi_o), .rst_req_o(rst_req_o)
);

// File: tb/test_kwdt_top.sv
`timescale 1ns/1ps
module test_kwdt_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_rdata;
    logic        nmi_o, rst_req_o;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    kwdt_top i_kwdt_top (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .nmi_o(nmi_o), .rst_req_o(rst_req_o)
    );

    // {we, addr, wdata, expected read}
    localparam int NV = 15;
    localparam logic [34:0] VEC [NV] = '{
        {1'b0, 2'd0, 16'h0000, 16'h0000},
        {1'b0, 2'd1, 16'h0000, 16'h000A},
        {1'b0, 2'd2, 16'h0000, 16'h03FF},
        {1'b1, 2'd2, 16'h0005, 16'h0000},
        {1'b0, 2'd2, 16'h0000, 16'h03FF},
        {1'b1, 2'd1, 16'h0001, 16'h0000},
        {1'b0, 2'd1, 16'h0000, 16'h000A},
        {1'b1, 2'd0, 16'h0096, 16'h0000},
        {1'b0, 2'd0, 16'h0000, 16'h0096},
        {1'b1, 2'd2, 16'hFC10, 16'h0000},
        {1'b0, 2'd2, 16'h0000, 16'h0010},
        {1'b1, 2'd0, 16'h1234, 16'h0000},
        {1'b1, 2'd2, 16'h0020, 16'h0000},
        {1'b0, 2'd2, 16'h0000, 16'h0010},
        {1'b0, 2'd3, 16'h0000, 16'h0000}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input string req, input logic [1:0] a, input logic [15:0] exp);
        bus_addr = a;
        #0.5;
        check(req, bus_rdata, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] c1;
        int first;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 nmi_o", {15'd0, nmi_o}, 16'd0);
        check("R1 rst_req_o", {15'd0, rst_req_o}, 16'd0);

        // table walk: R1 reset values, R2 gating and relock, R3 limit field
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][34]) wr(VEC[i][33:32], VEC[i][31:16]);
            else begin
                @(negedge clk);
                rd($sformatf("R1/R2/R3 vec%0d", i), VEC[i][33:32], VEC[i][15:0]);
            end
        end

        // R6/R8: limit 3, reset mode, clear+start
        wr(0, 16'h0096);
        wr(2, 16'h0003);
        wr(1, 16'h8000);
        bus_addr = 2'd3;
        for (int i = 0; i <= 8; i++) begin
            if (i > 0) @(negedge clk);
            rd("R6 count", 2'd3, 16'(i % 4));
            check("R8 rst pulse", {15'd0, rst_req_o}, {15'd0, (i > 0 && i % 4 == 0)});
        end

        // R4: halt holds count
        wr(1, 16'h000A);
        rd("R4 ctrl", 2'd1, 16'h000A);
        bus_addr = 2'd3; #0.5; c1 = bus_rdata;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            rd("R4 hold", 2'd3, c1);
            check("R4 no rst when stopped", {15'd0, rst_req_o}, 16'd0);
        end
        // R4: run code 5 resumes from held value
        wr(1, 16'h0005);
        rd("R4 resume", 2'd3, c1);
        @(negedge clk);
        rd("R4 advance", 2'd3, (c1 + 16'd1) % 16'd4);

        // R7: interrupt mode
        wr(1, 16'h8100);
        for (int i = 1; i <= 9; i++) begin
            @(negedge clk);
            check("R7 no rst in irq mode", {15'd0, rst_req_o}, 16'd0);
            if (i == 4) begin
                check("R7 nmi set", {15'd0, nmi_o}, 16'd1);
                rd("R7 status bit14", 2'd1, 16'h4100);
            end
        end
        check("R7 sticky", {15'd0, nmi_o}, 16'd1);
        // R2/R7: locked clear is ignored
        wr(0, 16'h0000);
        wr(1, 16'h8100);
        check("R2 locked clear ignored", {15'd0, nmi_o}, 16'd1);
        // R5/R7: accepted clear
        wr(0, 16'h0096);
        wr(1, 16'h8100);
        check("R7 cleared", {15'd0, nmi_o}, 16'd0);
        rd("R5 count zero", 2'd3, 16'd0);
        rd("R5 clear bit reads 0", 2'd1, 16'h0100);

        // R8: mode 2'b10 behaves as reset
        wr(1, 16'h8200);
        for (int i = 1; i <= 4; i++) @(negedge clk);
        check("R8 mode10 rst", {15'd0, rst_req_o}, 16'd1);
        check("R8 mode10 no nmi", {15'd0, nmi_o}, 16'd0);
        @(negedge clk);
        check("R8 one cycle", {15'd0, rst_req_o}, 16'd0);

        // R6: long period, limit 639 -> 640 edges
        wr(2, 16'd639);
        wr(1, 16'h8000);
        first = -1;
        for (int i = 1; i <= 700; i++) begin
            @(negedge clk);
            if (rst_req_o && first < 0) first = i;
        end
        check("R6 period 640", 16'(first), 16'd640);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule